// File: doc/BRIEF.md
# Keyed Index/Data Configuration Register File

This block holds a 256-entry bank of 8-bit chipset configuration registers that software reaches through a pair of I/O locations: one location latches a register number (the index), the other reads or writes the register the index selects. A key register guards the bank. Until it holds the key value 0xC5, every other register ignores writes. The key register itself can always be written. Once the bank is open, each register keeps only the bits its own write mask allows.

Some registers drive side-effect outputs. These are the two cache enables, the enable for the fast-reset/A20 control port, a one-cycle SMI request, and four PCI interrupt routing fields, each with an enable flag. A strap input marks a system with an alternate CPU whose own configuration space overlaps this one. While the strap is set, reads of index 0x20 and of every index from 0xC0 upward return 0xFF.

The lock is a two-state machine. LK_LOCKED is the reset state. It takes the transition *key match* to LK_OPEN when register 0x03 is written with 0xC5. LK_OPEN takes the transition *key clear* back to LK_LOCKED when register 0x03 is written with any other value. Every other input leaves the state where it is.

Top module: `cfg_index_port`

## Requirements
- R1: A write to I/O address 0x0022 latches the index. A write or read at I/O address 0x0023 accesses the register that the latched index selects.
- R2: Register 0x03 always accepts writes. Every other register accepts a write only while register 0x03 holds 0xC5. Writing register 0x03 with any other value locks the bank again.
- R3: An accepted write keeps only the masked bits and stores zero in the rest. The masks are: 0x14→0xBF, 0x15→0xF1, 0x1E→0x40, 0x22→0xFD, 0x2B→0xBF, 0x36→0xE5, 0x37→0xEF, 0x3D→0x07, 0x40→0x3F. Every other register keeps all 8 bits.
- R4: `icache_en` follows bit 0 of register 0x16, and `ecache_en` follows bit 1.
- R5: `fastrst_port_en` follows bit 4 of register 0x29.
- R6: An accepted write to register 0x35 with bit 4 or bit 5 set raises `smi_req` for exactly the one cycle after the write edge. Other values raise nothing.
- R7: Register 0x42 routes INTA from bits 3:0 and INTB from bits 7:4. Register 0x43 routes INTC and INTD the same way. `pirq_num` packs A, B, C, D in that order from bit 0 up. A line's `pirq_en` bit is 1 exactly when its nibble is nonzero.
- R8: While `alt_cpu_strap` is 1, reads of index 0x20 and of indices 0xC0 to 0xFF return 0xFF.
- R9: Reset loads 0x01=0x0F, 0x02=0x0F, 0x10=0xF1, 0x11=0xFF, 0x15=0x20, 0x16=0x30, 0x19=0x04, 0x21=0x72, 0x28=0x02, 0x2B=0xDB, 0x3C=0x03, 0x3D=0x01 and 0x40=0x03. All other registers reset to 0x00, so the bank starts in LK_LOCKED with all routing lines disabled.
- R10: Read data is registered and appears on `io_rdata` in the cycle after the read edge. It holds until the next read. A read of any address other than 0x0023 returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | I/O write strobe, one cycle |
| io_rd | input | 1 | I/O read strobe, one cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| alt_cpu_strap | input | 1 | Hides the overlapping indices when set |
| icache_en | output | 1 | Internal cache enable |
| ecache_en | output | 1 | External cache enable |
| fastrst_port_en | output | 1 | Fast-reset/A20 port enable |
| smi_req | output | 1 | One-cycle SMI request |
| pirq_num | output | 16 | IRQ numbers for INTA..INTD, 4 bits each |
| pirq_en | output | 4 | Routing enable per line, INTA at bit 0 |

## Verification
The hardest case to reach is a rejected write. It leaves nothing visible, so the bench follows each one with a read through the data port. It must also first return the bank to LK_LOCKED after unlocking it, which takes a second write of register 0x03 with a wrong key. The mask table runs only after the key has been loaded. The strap cases write a distinctive value into index 0xC0 with the strap clear, then read it with the strap set and clear again. This shows that hiding affects only the read path and never the stored value.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int IDX_W = 8;
    localparam int NREG  = 1 << IDX_W;

    typedef enum logic {
        LK_LOCKED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_state_t;

    localparam logic [IDX_W-1:0] KEY_IDX  = 8'h03;
    localparam logic [IDX_W-1:0] CACHE_IDX = 8'h16;
    localparam logic [IDX_W-1:0] CLKP_IDX = 8'h29;
    localparam logic [IDX_W-1:0] SMIS_IDX = 8'h35;
    localparam logic [IDX_W-1:0] RTAB_IDX = 8'h42;
    localparam logic [IDX_W-1:0] RTCD_IDX = 8'h43;

    function automatic logic [7:0] wr_mask(input logic [IDX_W-1:0] idx);
        unique case (idx)
            8'h14:   wr_mask = 8'hBF;
            8'h15:   wr_mask = 8'hF1;
            8'h1E:   wr_mask = 8'h40;
            8'h22:   wr_mask = 8'hFD;
            8'h2B:   wr_mask = 8'hBF;
            8'h36:   wr_mask = 8'hE5;
            8'h37:   wr_mask = 8'hEF;
            8'h3D:   wr_mask = 8'h07;
            8'h40:   wr_mask = 8'h3F;
            default: wr_mask = 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] reset_val(input logic [IDX_W-1:0] idx);
        unique case (idx)
            8'h01:   reset_val = 8'h0F;
            8'h02:   reset_val = 8'h0F;
            8'h10:   reset_val = 8'hF1;
            8'h11:   reset_val = 8'hFF;
            8'h15:   reset_val = 8'h20;
            8'h16:   reset_val = 8'h30;
            8'h19:   reset_val = 8'h04;
            8'h21:   reset_val = 8'h72;
            8'h28:   reset_val = 8'h02;
            8'h2B:   reset_val = 8'hDB;
            8'h3C:   reset_val = 8'h03;
            8'h3D:   reset_val = 8'h01;
            8'h40:   reset_val = 8'h03;
            default: reset_val = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfg_lock_fsm.sv
module cfg_lock_fsm
    import cfg_pkg::*;
#(
    parameter logic [7:0] KEY = 8'hC5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_val,
    output logic       unlocked
);

    lock_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: if (key_wr && key_val == KEY) state_d = LK_OPEN;
            LK_OPEN:   if (key_wr && key_val != KEY) state_d = LK_LOCKED;
            default:   state_d = LK_LOCKED;
        endcase
    end

    always_comb begin
        unlocked = (state_q == LK_OPEN);
    end

    // R2
    key_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_val == KEY) |=> unlocked);

    // R2
    key_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_val != KEY) |=> !unlocked);

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_val,
    output logic [7:0]       r_cache,
    output logic [7:0]       r_clkp,
    output logic [7:0]       r_rtab,
    output logic [7:0]       r_rtcd
);

    logic [7:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= reset_val(IDX_W'(i));
        end else if (we) begin
            mem[wr_idx] <= wr_val;
        end
    end

    always_comb begin
        rd_val  = mem[rd_idx];
        r_cache = mem[CACHE_IDX];
        r_clkp  = mem[CLKP_IDX];
        r_rtab  = mem[RTAB_IDX];
        r_rtcd  = mem[RTCD_IDX];
    end

    // R3
    mask_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((mem[$past(wr_idx)] & ~wr_mask($past(wr_idx))) == 8'h00));

endmodule

// File: rtl/cfg_side_fx.sv
module cfg_side_fx
    import cfg_pkg::*;
#(
    parameter int NLINE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smi_hit,
    input  logic [7:0]         smi_val,
    input  logic [7:0]         r_cache,
    input  logic [7:0]         r_clkp,
    input  logic [7:0]         r_rtab,
    input  logic [7:0]         r_rtcd,
    output logic               icache_en,
    output logic               ecache_en,
    output logic               fastrst_port_en,
    output logic               smi_req,
    output logic [4*NLINE-1:0] pirq_num,
    output logic [NLINE-1:0]   pirq_en
);

    localparam logic [7:0] SMI_TRIG = 8'h30;

    logic [4*NLINE-1:0] route_all;

    always_ff @(posedge clk) begin
        if (!rst_n) smi_req <= 1'b0;
        else        smi_req <= smi_hit && ((smi_val & SMI_TRIG) != 8'h00);
    end

    always_comb begin
        icache_en       = r_cache[0];
        ecache_en       = r_cache[1];
        fastrst_port_en = r_clkp[4];
        route_all       = {{(4*NLINE-16){1'b0}}, r_rtcd, r_rtab};
        pirq_num        = route_all;
    end

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        assign pirq_en[g] = (route_all[4*g +: 4] != 4'h0);
    end

    // R6
    smi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> $past(smi_hit));

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
    import cfg_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] IDX_PORT   = 16'h0022,
    parameter logic [15:0] DAT_PORT   = 16'h0023,
    parameter logic [7:0]  KEY        = 8'hC5,
    parameter logic [7:0]  HIDE_SOLO  = 8'h20,
    parameter logic [7:0]  HIDE_FLOOR = 8'hC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              alt_cpu_strap,
    output logic              icache_en,
    output logic              ecache_en,
    output logic              fastrst_port_en,
    output logic              smi_req,
    output logic [15:0]       pirq_num,
    output logic [3:0]        pirq_en
);

    localparam int NLINE = 4;

    logic [IDX_W-1:0] idx_q;
    logic             idx_wr, dat_wr, dat_rd, key_wr, bank_we, unlocked, hidden;
    logic [7:0]       bank_rd, r_cache, r_clkp, r_rtab, r_rtcd, masked;

    always_comb begin
        idx_wr  = io_wr && (io_addr == ADDR_W'(IDX_PORT));
        dat_wr  = io_wr && (io_addr == ADDR_W'(DAT_PORT));
        dat_rd  = io_rd && (io_addr == ADDR_W'(DAT_PORT));
        key_wr  = dat_wr && (idx_q == KEY_IDX);
        bank_we = key_wr || (dat_wr && unlocked);
        masked  = io_wdata & wr_mask(idx_q);
        hidden  = alt_cpu_strap && ((idx_q == HIDE_SOLO) || (idx_q >= HIDE_FLOOR));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else if (idx_wr) idx_q <= io_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) io_rdata <= 8'hFF;
        else if (io_rd) io_rdata <= (dat_rd && !hidden) ? bank_rd : 8'hFF;
    end

    cfg_lock_fsm #(.KEY(KEY)) u_lock (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr),
        .key_val(io_wdata), .unlocked(unlocked)
    );

    cfg_regbank u_bank (
        .clk(clk), .rst_n(rst_n), .we(bank_we), .wr_idx(idx_q),
        .wr_val(masked), .rd_idx(idx_q), .rd_val(bank_rd),
        .r_cache(r_cache), .r_clkp(r_clkp), .r_rtab(r_rtab), .r_rtcd(r_rtcd)
    );

    cfg_side_fx #(.NLINE(NLINE)) u_fx (
        .clk(clk), .rst_n(rst_n),
        .smi_hit(bank_we && idx_q == SMIS_IDX), .smi_val(io_wdata),
        .r_cache(r_cache), .r_clkp(r_clkp), .r_rtab(r_rtab), .r_rtcd(r_rtcd),
        .icache_en(icache_en), .ecache_en(ecache_en),
        .fastrst_port_en(fastrst_port_en), .smi_req(smi_req),
        .pirq_num(pirq_num), .pirq_en(pirq_en)
    );

    // R2
    lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we && idx_q != KEY_IDX) |-> unlocked);

    // R8
    strap_hide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && hidden) |=> (io_rdata == 8'hFF));

    // R1
    index_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (idx_q == $past(io_wdata)));

endmodule

// File: tb/sim_cfg_index_port.sv
module sim_cfg_index_port;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        alt_cpu_strap = 1'b0;
    logic        icache_en, ecache_en, fastrst_port_en, smi_req;
    logic [15:0] pirq_num;
    logic [3:0]  pirq_en;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_index_port u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .alt_cpu_strap(alt_cpu_strap), .icache_en(icache_en),
        .ecache_en(ecache_en), .fastrst_port_en(fastrst_port_en),
        .smi_req(smi_req), .pirq_num(pirq_num), .pirq_en(pirq_en)
    );

    // {index, written value, expected readback}
    localparam int NVEC = 11;
    localparam logic [23:0] VEC [NVEC] = '{
        24'h14_FF_BF, 24'h15_FF_F1, 24'h1E_FF_40, 24'h22_FF_FD,
        24'h2B_FF_BF, 24'h36_FF_E5, 24'h37_FF_EF, 24'h3D_FF_07,
        24'h40_FF_3F, 24'h10_5A_5A, 24'h80_A5_A5
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
        io_write(16'h0022, i);
        io_write(16'h0023, d);
    endtask

    task automatic reg_rd(input logic [7:0] i);
        io_write(16'h0022, i);
        io_read(16'h0023);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        chk("R9 cache", {icache_en, ecache_en}, 0);
        chk("R7 reset en", pirq_en, 0);
        chk("R9 smi", smi_req, 0);
        chk("R10 rdata reset", io_rdata, 8'hFF);
        reg_rd(8'h10); chk("R9 reg10", io_rdata, 8'hF1);
        reg_rd(8'h2B); chk("R9 reg2B", io_rdata, 8'hDB);
        reg_rd(8'h21); chk("R9 reg21", io_rdata, 8'h72);
        reg_rd(8'h40); chk("R9 reg40", io_rdata, 8'h03);

        // R2 locked writes ignored
        reg_wr(8'h10, 8'h12);
        reg_rd(8'h10); chk("R2 locked ignore", io_rdata, 8'hF1);
        reg_wr(8'h16, 8'h03);
        chk("R2 locked cache", {icache_en, ecache_en}, 0);

        // R2 key register always writable
        reg_wr(8'h03, 8'hC5);
        reg_rd(8'h03); chk("R2 key readback", io_rdata, 8'hC5);

        // R3 mask table walk
        for (int k = 0; k < NVEC; k++) begin
            reg_wr(VEC[k][23:16], VEC[k][15:8]);
            reg_rd(VEC[k][23:16]);
            chk("R3 mask", io_rdata, VEC[k][7:0]);
        end

        // R4
        reg_wr(8'h16, 8'h01);
        chk("R4 icache only", {icache_en, ecache_en}, 2'b10);
        reg_wr(8'h16, 8'h02);
        chk("R4 ecache only", {icache_en, ecache_en}, 2'b01);

        // R5
        reg_wr(8'h29, 8'h10);
        chk("R5 fast reset on", fastrst_port_en, 1);
        reg_wr(8'h29, 8'hEF);
        chk("R5 fast reset off", fastrst_port_en, 0);

        // R6: sample right after write edge, then next cycle
        io_write(16'h0022, 8'h35);
        @(negedge clk);
        io_addr = 16'h0023; io_wdata = 8'h20; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        chk("R6 smi pulse", smi_req, 1);
        @(negedge clk);
        chk("R6 smi one cycle", smi_req, 0);
        io_write(16'h0023, 8'h01);
        chk("R6 no smi", smi_req, 0);

        // R7 routing
        reg_wr(8'h42, 8'hB5);
        reg_wr(8'h43, 8'h0A);
        chk("R7 numbers", pirq_num, 16'h0AB5);
        chk("R7 enables", pirq_en, 4'b0111);

        // R8 strap hiding
        reg_wr(8'hC0, 8'h3C);
        reg_wr(8'h20, 8'h44);
        alt_cpu_strap = 1'b1;
        reg_rd(8'hC0); chk("R8 hide C0", io_rdata, 8'hFF);
        reg_rd(8'h20); chk("R8 hide 20", io_rdata, 8'hFF);
        reg_rd(8'h21); chk("R8 21 visible", io_rdata, 8'h72);
        alt_cpu_strap = 1'b0;
        reg_rd(8'hC0); chk("R8 C0 kept", io_rdata, 8'h3C);

        // R10 other address reads FF, data holds
        io_read(16'h0024); chk("R10 other addr", io_rdata, 8'hFF);
        reg_rd(8'h20);
        repeat (3) @(negedge clk);
        chk("R10 hold", io_rdata, 8'h44);

        // R1 index port itself does not read back the register
        io_read(16'h0022); chk("R1 idx port read", io_rdata, 8'hFF);

        // R2 relock
        reg_wr(8'h03, 8'h00);
        reg_wr(8'h11, 8'h00);
        reg_rd(8'h11); chk("R2 relocked", io_rdata, 8'hFF);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule